// File: doc/BRIEF.md
# Audio clock ratio detector

The detector sits at the front of a serial audio DAC and works out how the master clock relates to the frame (left/right) clock. It counts master-clock cycles across each full frame-clock period and maps the count onto one of eight supported ratios. The frame rate is the sample rate, so the count is the master-clock-to-sample-rate ratio. Each ratio is tied to a speed mode: single, double or quad. The frame clock is asynchronous to the master clock, so it is synchronised into the master-clock domain first. Periods are measured between successive synchronised rising edges.

The rest of the DAC reads three things from the block. It reads a ratio code and a speed code. It reads a valid flag, which stays low until two periods in a row give the same result. It reads an error flag, which marks a period whose length fits no supported ratio. Four ratios are legal in more than one speed mode. A fixed priority settles each of them on the slowest mode that allows it.

Top module: `audio_ratio_detect`

## Requirements
- R1: While `rst_n` is low, and after its release until the first measured period, `ratio_valid`, `ratio_err`, `ratio_code` and `speed_code` are all 0.
- R2: A period is the number of master-clock cycles between two successive rising edges of the frame clock. The first rising edge after reset only starts a measurement and leaves every output unchanged.
- R3: A period whose count is within ±2 cycles of a supported ratio matches it. The ratio code is 0=64, 1=96, 2=128, 3=192, 4=256, 5=384, 6=512, 7=768.
- R4: The speed code is 0 for single, 1 for double and 2 for quad. Single allows 256/384/512/768, double allows 128/192/256/384 and quad allows 64/96/128/192. The value 3 never appears.
- R5: A ratio legal in several modes takes the slowest one. So 256 and 384 report single, 128 and 192 report double, and only 64 and 96 report quad.
- R6: A period that matches no supported ratio sets `ratio_err` and clears `ratio_valid`, while `ratio_code` and `speed_code` keep their previous values. The next matching period clears `ratio_err`.
- R7: `ratio_valid` rises on a matching period whose ratio code equals that of the directly preceding period, provided that period also matched. It falls on the first period whose classification differs.
- R8: The outputs change only on the third master-clock rising edge after the edge that first samples the frame clock high. Between such updates they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrck_in | input | 1 | Frame (left/right) clock, asynchronous to `mclk` |
| ratio_valid | output | 1 | Two consecutive periods gave the same ratio |
| ratio_err | output | 1 | Last period matched no supported ratio |
| ratio_code | output | 3 | Encoded ratio of the last matching period |
| speed_code | output | 2 | Encoded speed mode of the last matching period |

## Verification
Every result is due at a fixed latency. The frame clock is sampled high at one master-clock edge and the outputs change three edges later. With inputs driven just after a rising edge, that is the fifth falling edge after the drive. The driver stamps each expected classification with that falling-edge number and queues it. The monitor compares all four outputs at every falling edge. On the stamped edge it first takes the new value from the queue. On every other edge it requires the previous value to hold, so a result that arrives early or late is caught, and so is a change at the first, unmeasured edge.

// File: rtl/arcd_pkg.sv
package arcd_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  localparam int unsigned NUM_RATIOS = 8;
  localparam int unsigned CODE_W     = $clog2(NUM_RATIOS);

  // Master-clock cycles per frame for each ratio code; codes ascend with the ratio.
  function automatic int unsigned ratio_of(input int unsigned code);
    case (code)
      0:       return 64;
      1:       return 96;
      2:       return 128;
      3:       return 192;
      4:       return 256;
      5:       return 384;
      6:       return 512;
      default: return 768;
    endcase
  endfunction

  // Slowest mode that allows the ratio wins.
  function automatic speed_e speed_of(input int unsigned code);
    if (code >= 4)      return SPD_SINGLE;
    else if (code >= 2) return SPD_DOUBLE;
    else                return SPD_QUAD;
  endfunction

endpackage

// File: rtl/arcd_rst_sync.sv
module arcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain[STAGES-1];
endmodule

// File: rtl/arcd_edge_sync.sv
module arcd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_i};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/arcd_period_ctr.sv
module arcd_period_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             stb_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W-1:0] meas_q, meas_nx;
  logic             primed_q, primed_nx;
  logic             stb_q, stb_nx;

  always_comb begin
    cnt_nx    = cnt_q;
    meas_nx   = meas_q;
    primed_nx = primed_q | rise_i;
    stb_nx    = rise_i & primed_q;
    if (rise_i) begin
      meas_nx = cnt_q;
      cnt_nx  = CNT_ONE;
    end else if (cnt_q != CNT_MAX) begin
      cnt_nx = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      meas_q   <= '0;
      primed_q <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      meas_q   <= meas_nx;
      primed_q <= primed_nx;
      stb_q    <= stb_nx;
    end
  end

  assign stb_o  = stb_q;
  assign meas_o = meas_q;
endmodule

// File: rtl/arcd_classify.sv
module arcd_classify
  import arcd_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TOL   = 2
) (
  input  logic [CNT_W-1:0]  meas_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        speed_o
);
  logic [NUM_RATIOS-1:0] in_win;
  logic [CNT_W:0]        meas_x;

  assign meas_x = {1'b0, meas_i};

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam logic [CNT_W:0] LO = (CNT_W+1)'(ratio_of(g) - TOL);
    localparam logic [CNT_W:0] HI = (CNT_W+1)'(ratio_of(g) + TOL);
    assign in_win[g] = (meas_x >= LO) && (meas_x <= HI);
  end

  always_comb begin
    hit_o   = 1'b0;
    code_o  = '0;
    speed_o = SPD_SINGLE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (in_win[i] && !hit_o) begin
        hit_o   = 1'b1;
        code_o  = CODE_W'(i);
        speed_o = speed_of(i);
      end
    end
  end
endmodule

// File: rtl/audio_ratio_detect.sv
module audio_ratio_detect
  import arcd_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned TOL         = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck_in,
  output logic       ratio_valid,
  output logic       ratio_err,
  output logic [2:0] ratio_code,
  output logic [1:0] speed_code
);
  logic             rst_q_n;
  logic             frame_rise;
  logic             meas_stb;
  logic [CNT_W-1:0] meas;
  logic             hit;
  logic [2:0]       cls_code;
  logic [1:0]       cls_speed;

  arcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(mclk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  arcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst_n(rst_q_n), .async_i(lrck_in), .rise_o(frame_rise)
  );

  arcd_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(mclk), .rst_n(rst_q_n), .rise_i(frame_rise),
    .stb_o(meas_stb), .meas_o(meas)
  );

  arcd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .meas_i(meas), .hit_o(hit), .code_o(cls_code), .speed_o(cls_speed)
  );

  logic       valid_q, valid_nx;
  logic       err_q, err_nx;
  logic [2:0] code_q, code_nx;
  logic [1:0] spd_q, spd_nx;
  logic       prev_ok_q, prev_ok_nx;

  always_comb begin
    valid_nx   = valid_q;
    err_nx     = err_q;
    code_nx    = code_q;
    spd_nx     = spd_q;
    prev_ok_nx = prev_ok_q;
    if (meas_stb) begin
      if (!hit) begin
        err_nx     = 1'b1;
        valid_nx   = 1'b0;
        prev_ok_nx = 1'b0;
      end else begin
        err_nx     = 1'b0;
        valid_nx   = prev_ok_q && (code_q == cls_code);
        code_nx    = cls_code;
        spd_nx     = cls_speed;
        prev_ok_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= '0;
      spd_q     <= '0;
      prev_ok_q <= 1'b0;
    end else begin
      valid_q   <= valid_nx;
      err_q     <= err_nx;
      code_q    <= code_nx;
      spd_q     <= spd_nx;
      prev_ok_q <= prev_ok_nx;
    end
  end

  assign ratio_valid = valid_q;
  assign ratio_err   = err_q;
  assign ratio_code  = code_q;
  assign speed_code  = spd_q;
endmodule

// File: rtl/audio_ratio_detect_chk.sv
module audio_ratio_detect_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic       ratio_valid,
  input logic       ratio_err,
  input logic [2:0] ratio_code,
  input logic [1:0] speed_code,
  input logic       meas_stb,
  input logic       hit
);
  AST_VALID_ERR_EXCL: assert property (@(posedge mclk) disable iff (!rst_n)
    !(ratio_valid && ratio_err)); // R6

  AST_SPEED_LEGAL: assert property (@(posedge mclk) disable iff (!rst_n)
    speed_code != 2'd3); // R4

  AST_SPEED_PRIO: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_valid |-> (speed_code == ((ratio_code >= 3'd4) ? 2'd0 :
                                    (ratio_code >= 3'd2) ? 2'd1 : 2'd2))); // R5

  AST_MISS_FLAGS: assert property (@(posedge mclk) disable iff (!rst_n)
    (meas_stb && !hit) |=> (ratio_err && !ratio_valid)); // R6

  AST_MISS_HOLDS_CODE: assert property (@(posedge mclk) disable iff (!rst_n)
    (meas_stb && !hit) |=> ($stable(ratio_code) && $stable(speed_code))); // R6

  AST_VALID_SAME_CODE: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $stable(ratio_code)); // R7

  AST_HOLD_NO_STB: assert property (@(posedge mclk) disable iff (!rst_n)
    !meas_stb |=> ($stable(ratio_valid) && $stable(ratio_err) &&
                   $stable(ratio_code) && $stable(speed_code))); // R8
endmodule

bind audio_ratio_detect audio_ratio_detect_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .ratio_valid(ratio_valid), .ratio_err(ratio_err),
  .ratio_code(ratio_code), .speed_code(speed_code),
  .meas_stb(meas_stb), .hit(hit)
);

// File: tb/tb_audio_ratio_detect.sv
`timescale 1ns/1ps
module tb_audio_ratio_detect;
  logic       mclk = 1'b0;
  logic       rst_n;
  logic       lrck_in;
  logic       ratio_valid, ratio_err;
  logic [2:0] ratio_code;
  logic [1:0] speed_code;

  always #2 mclk = ~mclk; // 250 MHz

  audio_ratio_detect dut (
    .mclk(mclk), .rst_n(rst_n), .lrck_in(lrck_in),
    .ratio_valid(ratio_valid), .ratio_err(ratio_err),
    .ratio_code(ratio_code), .speed_code(speed_code)
  );

  typedef struct {
    int         due;
    logic       valid;
    logic       err;
    logic [2:0] code;
    logic [1:0] spd;
    string      tag;
  } exp_t;

  exp_t  sbq[$];
  exp_t  cur;
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  string hold_tag = "R1";
  bit    done = 0;

  // reference model state
  bit         m_prev_ok = 0;
  logic [2:0] m_code = '0;
  logic [1:0] m_spd = '0;
  logic       m_valid = 0, m_err = 0;
  int         last_p = 0;
  string      last_tag = "";

  function automatic int code_of(input int r);
    case (r)
      64: return 0; 96: return 1; 128: return 2; 192: return 3;
      256: return 4; 384: return 5; 512: return 6; default: return 7;
    endcase
  endfunction

  // single=0, double=1, quad=2, searched slowest first (R5)
  function automatic void classify(input int p, output bit hit,
                                   output logic [2:0] code, output logic [1:0] spd);
    int legal [3][4] = '{'{256, 384, 512, 768}, '{128, 192, 256, 384}, '{64, 96, 128, 192}};
    hit = 0; code = '0; spd = '0;
    for (int m = 0; m < 3; m++)
      for (int j = 0; j < 4; j++)
        if (!hit && p >= legal[m][j] - 2 && p <= legal[m][j] + 2) begin
          hit = 1; code = 3'(code_of(legal[m][j])); spd = 2'(m);
        end
  endfunction

  function automatic void model_step(input int p);
    bit hit; logic [2:0] c; logic [1:0] s;
    classify(p, hit, c, s);
    if (!hit) begin
      m_err = 1; m_valid = 0; m_prev_ok = 0;
    end else begin
      m_err = 0;
      m_valid = m_prev_ok && (m_code == c);
      m_code = c; m_spd = s; m_prev_ok = 1;
    end
  endfunction

  // Drives one frame-clock period of p cycles starting with a rising edge.
  task automatic run_period(input int p, input string tag);
    exp_t e;
    lrck_in = 1'b1;
    if (last_p > 0) begin
      model_step(last_p);
      e.due = cyc + 5; e.valid = m_valid; e.err = m_err;
      e.code = m_code; e.spd = m_spd; e.tag = last_tag;
      sbq.push_back(e);
      hold_tag = "R8";
    end else begin
      hold_tag = "R2"; // first edge only starts a measurement
    end
    last_p = p; last_tag = tag;
    repeat (p / 2) begin @(posedge mclk); #1; end
    lrck_in = 1'b0;
    repeat (p - p / 2) begin @(posedge mclk); #1; end
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge mclk) begin
    string t;
    if (!done) begin
      cyc++;
      t = hold_tag;
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        cur = sbq.pop_front();
        t = cur.tag;
      end
      cmp(t, "valid", int'(ratio_valid), int'(cur.valid));
      cmp(t, "err",   int'(ratio_err),   int'(cur.err));
      cmp(t, "code",  int'(ratio_code),  int'(cur.code));
      cmp(t, "speed", int'(speed_code),  int'(cur.spd));
      if (cyc > 200000) begin
        failures++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    cur.due = 0; cur.valid = 0; cur.err = 0; cur.code = '0; cur.spd = '0; cur.tag = "R1";
    rst_n = 1'b0;
    lrck_in = 1'b0;
    repeat (5) @(posedge mclk);
    #1 rst_n = 1'b1;
    repeat (20) begin @(posedge mclk); #1; end

    run_period(256, "R3");  // first edge: nothing reported (R2)
    run_period(256, "R7");  // 256 single, not yet valid
    run_period(257, "R7");  // valid rises
    run_period(254, "R3");  // tolerance edge -2
    run_period(259, "R6");  // outside window: error
    run_period(384, "R6");  // error clears, ratio held before
    run_period(384, "R5");  // 384 single
    run_period(128, "R5");  // 128 double
    run_period(130, "R5");
    run_period(192, "R4");
    run_period(64,  "R4");  // quad
    run_period(62,  "R3");  // tolerance -2 still 64
    run_period(96,  "R4");
    run_period(96,  "R7");
    run_period(768, "R4");
    run_period(770, "R3");  // tolerance +2
    run_period(512, "R7");  // differs: valid drops
    run_period(500, "R6");
    run_period(61,  "R6");  // miss near 64
    run_period(512, "R6");
    run_period(512, "R7");
    run_period(300, "R8");  // closing edge for the last period

    repeat (20) begin @(posedge mclk); #1; end
    checks++;
    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL R8 pending=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule